// File: doc/BRIEF.md
# Dual-Fetch Next-PC Selector

This block owns the fetch program counter of a front end that reads two consecutive instructions per cycle. Every cycle it picks the address of the next fetch packet from four candidates: a correction address coming back from the memory stage after a branch mispredict, the target of a branch that the predictor reports as taken, the fetch PC plus two instruction widths, and the fetch PC plus one instruction width. The issue stage asks for the one-width step when it could send only one instruction of the pair and kept the other in its hold register.

The block also chooses the address that goes to the branch predictor for lookup. When the instruction waiting in the decode-stage hold register is a branch, the predictor looks up that instruction's PC. Otherwise it looks up the current fetch PC. A small two-state controller tracks whether the PC has moved since reset: in `ST_BOOT` the predictor's answer is ignored, and the first load of the PC register (transition `BOOT_TO_RUN`) moves it to `ST_RUN`, where it stays (`RUN_HOLD`) until the next reset. A stall input freezes the PC register. A mispredict correction is still loaded during a stall.

Top module: `nextpc_selector`

## Requirements
- R1: While reset (`rst_n` low) is applied, and after it is released until the first clock edge, `fetch_pc_o` equals the reset vector parameter (default 0x0000_1000) with its low two bits cleared.
- R2: With no mispredict, no usable prediction and `rollback_i` low, `next_pc_o` equals `fetch_pc_o + 8`.
- R3: With no mispredict, no usable prediction and `rollback_i` high, `next_pc_o` equals `fetch_pc_o + 4`.
- R4: In state `ST_RUN`, with no mispredict and `pred_taken_i` high, `next_pc_o` equals `pred_target_i` with its low two bits cleared, whatever the value of `rollback_i`.
- R5: With `mispredict_i` high, `next_pc_o` equals `resolved_pc_i` with its low two bits cleared, whatever the values of the prediction, rollback and stall inputs.
- R6: `lookup_pc_o` equals `held_pc_i` (low two bits cleared) when `held_is_branch_i` is high, and `fetch_pc_o` otherwise.
- R7: From reset until the first clock edge that loads the PC register, the controller is in `ST_BOOT` and `pred_taken_i` has no effect on `next_pc_o`.
- R8: On a clock edge with `stall_i` high and `mispredict_i` low, `fetch_pc_o` keeps its value.
- R9: On a clock edge with `mispredict_i` high, `fetch_pc_o` takes the aligned `resolved_pc_i`, even when `stall_i` is high.
- R10: Bits [1:0] of `next_pc_o` and of `lookup_pc_o` are always zero.
- R11: On a clock edge with `stall_i` low, `fetch_pc_o` takes the value `next_pc_o` had before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Freeze the PC register this cycle |
| rollback_i | input | 1 | Issue stage kept one instruction back; step by one instruction |
| pred_taken_i | input | 1 | Predictor reports a taken branch for the looked-up PC |
| pred_target_i | input | 32 | Predicted branch target |
| mispredict_i | input | 1 | Memory stage found a wrong prediction |
| resolved_pc_i | input | 32 | Correct address after a mispredict |
| held_is_branch_i | input | 1 | Instruction in the decode hold register is a branch |
| held_pc_i | input | 32 | PC of the instruction in the decode hold register |
| fetch_pc_o | output | 32 | Current fetch PC (register) |
| next_pc_o | output | 32 | Address of the next fetch packet (combinational) |
| lookup_pc_o | output | 32 | Address sent to the branch predictor (combinational) |

## Verification
The only hidden state is the PC register and the boot/run flag, and both surface within one cycle: a wrong PC appears directly on `fetch_pc_o` and shifts every later `next_pc_o`, while a controller that leaves `ST_BOOT` too early or too late shows up as a predicted target (or a sequential value) on `next_pc_o` in the first cycle after reset when `pred_taken_i` is high. The bench keeps a model of the PC and of the boot flag, and compares all three outputs every cycle. Directed cases cover a prediction in the boot cycle, stalls with and without a correction, misaligned targets and held branches. Random stimulus covers the overlaps of all the selection inputs.

// File: rtl/nps_pkg.sv
package nps_pkg;
    // Which candidate drives the next fetch address
    typedef enum logic [1:0] {
        SRC_SEQ_FULL = 2'd0,
        SRC_SEQ_HALF = 2'd1,
        SRC_PRED     = 2'd2,
        SRC_FIX      = 2'd3
    } nps_src_e;

    // Controller state: has the PC moved since reset?
    typedef enum logic {
        ST_BOOT = 1'b0,
        ST_RUN  = 1'b1
    } nps_state_e;
endpackage

// File: rtl/nps_seq_step.sv
module nps_seq_step #(
    parameter int ADDR_W      = 32,
    parameter int INSTR_BYTES = 4,
    parameter int FETCH_WIDTH = 2
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              rollback_i,
    output logic [ADDR_W-1:0] seq_full_o,
    output logic [ADDR_W-1:0] seq_half_o
);
    localparam logic [ADDR_W-1:0] STEP_ONE = ADDR_W'(INSTR_BYTES);
    localparam logic [ADDR_W-1:0] STEP_ALL = ADDR_W'(INSTR_BYTES * FETCH_WIDTH);

    always_comb begin
        seq_full_o = pc_i + STEP_ALL;
        seq_half_o = pc_i + STEP_ONE;
    end

    // R3: a rollback step is always smaller than the full-packet step
    always_comb begin
        if (rollback_i && FETCH_WIDTH > 1) begin
            a_half_lt_full_r3: assert ((seq_full_o - seq_half_o) == ADDR_W'(INSTR_BYTES * (FETCH_WIDTH - 1)));
        end
    end
endmodule

// File: rtl/nps_src_arbiter.sv
module nps_src_arbiter
    import nps_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mispredict_i,
    input  logic              pred_ok_i,
    input  logic              pred_taken_i,
    input  logic              rollback_i,
    input  logic [ADDR_W-1:0] resolved_pc_i,
    input  logic [ADDR_W-1:0] pred_target_i,
    input  logic [ADDR_W-1:0] seq_full_i,
    input  logic [ADDR_W-1:0] seq_half_i,
    output nps_src_e          src_o,
    output logic [ADDR_W-1:0] next_o
);
    localparam logic [ADDR_W-1:0] LOW_MASK =
        ~((ADDR_W'(1) << ALIGN_BITS) - ADDR_W'(1));

    logic [ADDR_W-1:0] raw_next;

    // Priority: correction, then usable prediction, then sequential step
    always_comb begin
        if (mispredict_i)                    src_o = SRC_FIX;
        else if (pred_ok_i && pred_taken_i)  src_o = SRC_PRED;
        else if (rollback_i)                 src_o = SRC_SEQ_HALF;
        else                                 src_o = SRC_SEQ_FULL;
    end

    always_comb begin
        unique case (src_o)
            SRC_FIX:      raw_next = resolved_pc_i;
            SRC_PRED:     raw_next = pred_target_i;
            SRC_SEQ_HALF: raw_next = seq_half_i;
            SRC_SEQ_FULL: raw_next = seq_full_i;
            default:      raw_next = seq_full_i;
        endcase
        next_o = raw_next & LOW_MASK;
    end

    // R5: a correction is never shadowed by any other candidate
    p_fix_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict_i |-> (next_o == (resolved_pc_i & LOW_MASK)));

    // R4: a usable taken prediction beats the sequential path
    p_pred_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mispredict_i && pred_ok_i && pred_taken_i) |-> (next_o == (pred_target_i & LOW_MASK)));

    // R10: selected address is aligned
    p_next_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (next_o[ALIGN_BITS-1:0] == '0));
endmodule

// File: rtl/nps_lookup_mux.sv
module nps_lookup_mux #(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_BITS = 2
) (
    input  logic              held_is_branch_i,
    input  logic [ADDR_W-1:0] held_pc_i,
    input  logic [ADDR_W-1:0] fetch_pc_i,
    output logic [ADDR_W-1:0] lookup_pc_o
);
    localparam logic [ADDR_W-1:0] LOW_MASK =
        ~((ADDR_W'(1) << ALIGN_BITS) - ADDR_W'(1));

    always_comb begin
        if (held_is_branch_i) lookup_pc_o = held_pc_i & LOW_MASK;
        else                  lookup_pc_o = fetch_pc_i & LOW_MASK;
    end
endmodule

// File: rtl/nextpc_selector.sv
module nextpc_selector
    import nps_pkg::*;
#(
    parameter int          ADDR_W      = 32,
    parameter int          INSTR_BYTES = 4,
    parameter int          FETCH_WIDTH = 2,
    parameter logic [31:0] RESET_VEC   = 32'h0000_1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        stall_i,
    input  logic        rollback_i,
    input  logic        pred_taken_i,
    input  logic [31:0] pred_target_i,
    input  logic        mispredict_i,
    input  logic [31:0] resolved_pc_i,
    input  logic        held_is_branch_i,
    input  logic [31:0] held_pc_i,
    output logic [31:0] fetch_pc_o,
    output logic [31:0] next_pc_o,
    output logic [31:0] lookup_pc_o
);
    localparam int ALIGN_BITS = (INSTR_BYTES > 1) ? $clog2(INSTR_BYTES) : 1;
    localparam logic [ADDR_W-1:0] LOW_MASK =
        ~((ADDR_W'(1) << ALIGN_BITS) - ADDR_W'(1));
    localparam logic [ADDR_W-1:0] BOOT_PC = ADDR_W'(RESET_VEC) & LOW_MASK;

    nps_state_e        state_q, state_d;
    logic              pc_load;
    logic              pred_ok;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] seq_full, seq_half;
    logic [ADDR_W-1:0] next_pc;
    nps_src_e          src_sel;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // Next state: BOOT_TO_RUN on the first PC load, RUN_HOLD afterwards
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT: if (mispredict_i || !stall_i) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_BOOT;
        endcase
    end

    // Controller outputs
    always_comb begin
        pc_load = mispredict_i || !stall_i;
        unique case (state_q)
            ST_BOOT: pred_ok = 1'b0;
            ST_RUN:  pred_ok = 1'b1;
            default: pred_ok = 1'b0;
        endcase
    end

    // PC register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pc_q <= BOOT_PC;
        else if (pc_load) pc_q <= next_pc;
    end

    nps_seq_step #(
        .ADDR_W      (ADDR_W),
        .INSTR_BYTES (INSTR_BYTES),
        .FETCH_WIDTH (FETCH_WIDTH)
    ) u_step (
        .pc_i       (pc_q),
        .rollback_i (rollback_i),
        .seq_full_o (seq_full),
        .seq_half_o (seq_half)
    );

    nps_src_arbiter #(
        .ADDR_W     (ADDR_W),
        .ALIGN_BITS (ALIGN_BITS)
    ) u_arb (
        .clk           (clk),
        .rst_n         (rst_n),
        .mispredict_i  (mispredict_i),
        .pred_ok_i     (pred_ok),
        .pred_taken_i  (pred_taken_i),
        .rollback_i    (rollback_i),
        .resolved_pc_i (ADDR_W'(resolved_pc_i)),
        .pred_target_i (ADDR_W'(pred_target_i)),
        .seq_full_i    (seq_full),
        .seq_half_i    (seq_half),
        .src_o         (src_sel),
        .next_o        (next_pc)
    );

    nps_lookup_mux #(
        .ADDR_W     (ADDR_W),
        .ALIGN_BITS (ALIGN_BITS)
    ) u_look (
        .held_is_branch_i (held_is_branch_i),
        .held_pc_i        (ADDR_W'(held_pc_i)),
        .fetch_pc_i       (pc_q),
        .lookup_pc_o      (lookup_pc_o)
    );

    assign fetch_pc_o = 32'(pc_q);
    assign next_pc_o  = 32'(next_pc);

    // R7: no prediction is used before the PC first moves
    p_boot_no_pred_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BOOT) |-> (src_sel != SRC_PRED));

    // R11: an unstalled edge loads the selected address
    p_advance_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_i |=> (fetch_pc_o == $past(next_pc_o)));

    // R8: a stall without correction freezes the PC
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_i && !mispredict_i) |=> $stable(fetch_pc_o));

    // R9: a correction lands even while stalled
    p_fix_in_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict_i |=> (fetch_pc_o == ($past(resolved_pc_i) & 32'hFFFF_FFFC)));

    // R2: plain sequential step covers a full packet
    p_seq_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mispredict_i && !pred_taken_i && !rollback_i) |-> (next_pc_o == fetch_pc_o + 32'd8));

    // R10: lookup address aligned
    p_lookup_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_pc_o[1:0] == 2'b00));
endmodule

// File: tb/nextpc_selector_tb.sv
module nextpc_selector_tb;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] RST_VEC    = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall_i = 1'b0, rollback_i = 1'b0, pred_taken_i = 1'b0;
    logic        mispredict_i = 1'b0, held_is_branch_i = 1'b0;
    logic [31:0] pred_target_i = '0, resolved_pc_i = '0, held_pc_i = '0;
    logic [31:0] fetch_pc_o, next_pc_o, lookup_pc_o;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;

    logic [31:0] m_pc;
    logic        m_boot;
    logic [31:0] m_next;

    always #(CLK_PERIOD/2) clk = ~clk;

    nextpc_selector #(.RESET_VEC(RST_VEC)) u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .stall_i          (stall_i),
        .rollback_i       (rollback_i),
        .pred_taken_i     (pred_taken_i),
        .pred_target_i    (pred_target_i),
        .mispredict_i     (mispredict_i),
        .resolved_pc_i    (resolved_pc_i),
        .held_is_branch_i (held_is_branch_i),
        .held_pc_i        (held_pc_i),
        .fetch_pc_o       (fetch_pc_o),
        .next_pc_o        (next_pc_o),
        .lookup_pc_o      (lookup_pc_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_next(input logic [31:0] pc, input logic boot,
                                             input logic rb, input logic pt, input logic [31:0] tgt,
                                             input logic mp, input logic [31:0] rpc);
        if (mp)              return rpc & 32'hFFFF_FFFC;
        else if (pt && !boot) return tgt & 32'hFFFF_FFFC;
        else if (rb)         return pc + 32'd4;
        else                 return pc + 32'd8;
    endfunction

    function automatic string next_tag(input logic boot, input logic rb, input logic pt, input logic mp);
        if (mp)            return "R5";
        else if (pt && boot) return "R7";
        else if (pt)       return "R4";
        else if (rb)       return "R3";
        else               return "R2";
    endfunction

    // Called at a falling edge: drive, check combinational outputs, clock, check PC
    task automatic step(input logic st, input logic rb, input logic pt, input logic [31:0] tgt,
                        input logic mp, input logic [31:0] rpc, input logic hb, input logic [31:0] hpc);
        stall_i = st; rollback_i = rb; pred_taken_i = pt; pred_target_i = tgt;
        mispredict_i = mp; resolved_pc_i = rpc; held_is_branch_i = hb; held_pc_i = hpc;
        #1;
        m_next = exp_next(m_pc, m_boot, rb, pt, tgt, mp, rpc);
        chk(next_tag(m_boot, rb, pt, mp), next_pc_o, m_next);
        chk("R10", {30'd0, next_pc_o[1:0]}, 32'd0);
        chk("R6", lookup_pc_o, hb ? (hpc & 32'hFFFF_FFFC) : m_pc);
        @(posedge clk);
        if (mp || !st) begin
            m_pc   = m_next;
            m_boot = 1'b0;
        end
        @(negedge clk);
        chk(mp && st ? "R9" : (st ? "R8" : "R11"), fetch_pc_o, m_pc);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_pc   = RST_VEC;
        m_boot = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", fetch_pc_o, RST_VEC);
        rst_n = 1'b1;
        #1;
        chk("R1", fetch_pc_o, RST_VEC);

        // Boot cycle stalled with a prediction: still ignored, PC frozen
        step(1'b1, 1'b0, 1'b1, 32'h0000_8000, 1'b0, 32'h0, 1'b0, 32'h0);
        // First loading cycle with a prediction: ignored (R7)
        step(1'b0, 1'b0, 1'b1, 32'h0000_8000, 1'b0, 32'h0, 1'b0, 32'h0);
        // Now running: prediction with misaligned target (R4, R10)
        step(1'b0, 1'b1, 1'b1, 32'h0000_2347, 1'b0, 32'h0, 1'b1, 32'h0000_0ABF);
        // Rollback step (R3)
        step(1'b0, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0);
        // Full step (R2)
        step(1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 32'h0000_4444);
        // Stall without correction (R8)
        step(1'b1, 1'b0, 1'b1, 32'h0000_9000, 1'b0, 32'h0, 1'b0, 32'h0);
        // Correction during stall, beating prediction and rollback (R9, R5)
        step(1'b1, 1'b1, 1'b1, 32'h0000_9000, 1'b1, 32'h0000_7003, 1'b0, 32'h0);
        // Correction not stalled
        step(1'b0, 1'b0, 1'b1, 32'h0000_9000, 1'b1, 32'hFFFF_FFFE, 1'b1, 32'h0000_0013);
        // Wrap-around sequential step
        step(1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0);

        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 5) == 0, ($urandom % 3) == 0, ($urandom % 4) == 0, $urandom,
                 ($urandom % 10) == 0, $urandom, ($urandom % 3) == 0, $urandom);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule